// File: doc/BRIEF.md
# Serial Port Status and Interrupt Unit

This block keeps the status word and raises the single interrupt for a synchronous serial port that has a transmit FIFO and a receive FIFO. It watches the fill levels of both FIFOs, host pushes and pops, the serial engine's slot and word strobes, frame-sync pulses with their bit timing, and the slot numbers given to data and control. From these it forms twelve status bits and one interrupt line. The shift register and the FIFO storage sit outside the block.

Six of the status bits show live conditions: two threshold requests, FIFO empty and full, and two control-register handshake signals. The other six are sticky error flags. An error flag stays set until the host writes a one to its bit. The host writes an enable mask, and the interrupt is a registered OR of every status bit whose enable bit is set.

Top module: `serial_status_irq`

## Requirements
- R1: `irq` is a register. At each clock edge it takes the OR of (status AND mask), using the status and mask values from the cycle before that edge.
- R2: Reset sets the mask to 0, clears all six error flags (status bits 11..6) and clears `irq`.
- R3: Status bit 0 (transmit request) equals `tx_level >= tx_thresh`. Status bit 1 (transmit empty) equals `tx_level == 0`. Both follow the inputs in the same cycle.
- R4: Status bit 2 (receive request) equals `rx_level >= rx_thresh`. Status bit 3 (receive full) equals `rx_level == DEPTH`. Both follow the inputs in the same cycle.
- R5: Status bit 4 follows `tx_ctl_free` and status bit 5 follows `rx_ctl_valid`.
- R6: Bit 6 sets after a cycle with `tx_push` while `tx_level == DEPTH`. Bit 7 sets after a cycle with `tx_slot` while `tx_level == 0`.
- R7: Bit 8 sets after a cycle with `rx_word` while `rx_level == DEPTH`. Bit 9 sets after a cycle with `rx_pop` while `rx_level == 0`.
- R8: Bit 10 sets when all of these hold in one cycle: `slave_mode` is 1, `sync_pulse` is 1, an earlier sync pulse has been seen since reset, and fewer than `frame_bits` `bit_strobe` cycles have passed since that earlier pulse. In master mode this bit never sets.
- R9: Bit 11 sets in any cycle where `ctl_slot_en` is 1 and `data_slot == ctl_slot`.
- R10: A host write to address 0 clears every error flag whose data bit is 1. Data bits that are 0, and data bits 5..0, have no effect.
- R11: If an error event and a clear of the same flag occur in the same cycle, the flag ends up set.
- R12: A host write to address 1 loads the mask from `host_wr_data`. Reading address 1 returns the mask and reading address 0 returns the status word, both combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_addr | input | 1 | 0 = clear error flags, 1 = load mask |
| host_wr_data | input | 12 | Write data |
| host_rd_addr | input | 1 | 0 = status, 1 = mask |
| host_rd_data | output | 12 | Read data |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_thresh | input | LVL_W | Transmit request threshold |
| rx_thresh | input | LVL_W | Receive request threshold |
| tx_push | input | 1 | Host write into the transmit FIFO |
| rx_pop | input | 1 | Host read from the receive FIFO |
| tx_slot | input | 1 | Serial transmit slot arrives |
| rx_word | input | 1 | Serial word received |
| tx_ctl_free | input | 1 | Transmit control register can accept a write |
| rx_ctl_valid | input | 1 | Receive control register holds valid data |
| slave_mode | input | 1 | Frame sync is supplied from outside |
| sync_pulse | input | 1 | Frame-sync pulse |
| bit_strobe | input | 1 | One serial bit time has passed |
| frame_bits | input | CNT_W | Expected number of bits per frame |
| data_slot | input | SLOT_W | Slot number used for serial data |
| ctl_slot | input | SLOT_W | Slot number used for control data |
| ctl_slot_en | input | 1 | Control slot is in use |
| irq | output | 1 | Combined interrupt |

## Verification
The threshold and level flags are swept over every pair of level and threshold from 0 to the FIFO depth. This separates `>=` from `>` and exposes wrong empty or full decodes at both ends of the range. Each error flag is first driven from both its triggering and its non-triggering condition, then cleared with single-bit patterns, all-ones patterns and all-zeros patterns. These show whether the clears are selective and whether the level bits ignore writes. The frame-sync check compares an early pulse, an on-time pulse and an early pulse in master mode. The interrupt is sampled one and two edges after a mask write, which separates a registered output from a combinational one.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
    localparam int NLVL = 6;
    localparam int NERR = 6;
    localparam int NFLAG = NLVL + NERR;

    typedef struct packed {
        logic rx_ctl;
        logic tx_ctl;
        logic rx_full;
        logic rx_req;
        logic tx_empty;
        logic tx_req;
    } lvl_t;

    typedef struct packed {
        logic slot_err;
        logic sync_err;
        logic rx_udf;
        logic rx_ovf;
        logic tx_udf;
        logic tx_ovf;
    } err_t;

    function automatic logic sticky_next(input logic cur, input logic ev, input logic clr);
        return ev | (cur & ~clr);
    endfunction
endpackage

// File: rtl/sfs_level_flags.sv
module sfs_level_flags
    import sfs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_thresh,
    input  logic [LVL_W-1:0] rx_thresh,
    input  logic             tx_ctl_free,
    input  logic             rx_ctl_valid,
    output lvl_t             lvl,
    output logic             tx_full,
    output logic             rx_empty
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    always_comb begin
        lvl.tx_req   = (tx_level >= tx_thresh);
        lvl.tx_empty = (tx_level == '0);
        lvl.rx_req   = (rx_level >= rx_thresh);
        lvl.rx_full  = (rx_level == FULL_LVL);
        lvl.tx_ctl   = tx_ctl_free;
        lvl.rx_ctl   = rx_ctl_valid;
        tx_full      = (tx_level == FULL_LVL);
        rx_empty     = (rx_level == '0);
    end
endmodule

// File: rtl/sfs_sync_check.sv
module sfs_sync_check #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slave_mode,
    input  logic             sync_pulse,
    input  logic             bit_strobe,
    input  logic [CNT_W-1:0] frame_bits,
    output logic             early_sync
);
    logic [CNT_W-1:0] bit_cnt;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            armed   <= 1'b0;
        end else if (sync_pulse) begin
            bit_cnt <= '0;
            armed   <= 1'b1;
        end else if (bit_strobe && bit_cnt != '1) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign early_sync = slave_mode & sync_pulse & armed & (bit_cnt < frame_bits);

    assert_sync_restart_R8: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |=> (bit_cnt == '0 && armed));
    assert_master_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !slave_mode |-> !early_sync);
endmodule

// File: rtl/sfs_sticky_bank.sv
module sfs_sticky_bank
    import sfs_pkg::*;
#(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= sticky_next(q[i], ev[i], clr[i]);
        end

        assert_event_wins_R11: assert property (@(posedge clk) disable iff (rst)
            ev[i] |=> q[i]);
        assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
            (q[i] && !clr[i]) |=> q[i]);
    end
endmodule

// File: rtl/serial_status_irq.sv
module serial_status_irq
    import sfs_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int SLOT_W = 3,
    parameter int CNT_W  = 6,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic              host_wr_addr,
    input  logic [NFLAG-1:0]  host_wr_data,
    input  logic              host_rd_addr,
    output logic [NFLAG-1:0]  host_rd_data,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_thresh,
    input  logic [LVL_W-1:0]  rx_thresh,
    input  logic              tx_push,
    input  logic              rx_pop,
    input  logic              tx_slot,
    input  logic              rx_word,
    input  logic              tx_ctl_free,
    input  logic              rx_ctl_valid,
    input  logic              slave_mode,
    input  logic              sync_pulse,
    input  logic              bit_strobe,
    input  logic [CNT_W-1:0]  frame_bits,
    input  logic [SLOT_W-1:0] data_slot,
    input  logic [SLOT_W-1:0] ctl_slot,
    input  logic              ctl_slot_en,
    output logic              irq
);
    lvl_t             lvl;
    err_t             ev, err_q;
    logic             tx_full, rx_empty, early_sync;
    logic [NERR-1:0]  clr;
    logic [NFLAG-1:0] status, mask;

    sfs_level_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_lvl (
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
        .tx_ctl_free(tx_ctl_free), .rx_ctl_valid(rx_ctl_valid),
        .lvl(lvl), .tx_full(tx_full), .rx_empty(rx_empty)
    );

    sfs_sync_check #(.CNT_W(CNT_W)) u_sync (
        .clk(clk), .rst(rst), .slave_mode(slave_mode), .sync_pulse(sync_pulse),
        .bit_strobe(bit_strobe), .frame_bits(frame_bits), .early_sync(early_sync)
    );

    always_comb begin
        ev.tx_ovf   = tx_push & tx_full;
        ev.tx_udf   = tx_slot & lvl.tx_empty;
        ev.rx_ovf   = rx_word & lvl.rx_full;
        ev.rx_udf   = rx_pop & rx_empty;
        ev.sync_err = early_sync;
        ev.slot_err = ctl_slot_en & (data_slot == ctl_slot);
    end

    assign clr = (host_wr_en && !host_wr_addr) ? host_wr_data[NFLAG-1:NLVL] : '0;

    sfs_sticky_bank #(.N(NERR)) u_err (
        .clk(clk), .rst(rst), .ev(ev), .clr(clr), .q(err_q)
    );

    assign status       = {err_q, lvl};
    assign host_rd_data = host_rd_addr ? mask : status;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            irq  <= 1'b0;
        end else begin
            if (host_wr_en && host_wr_addr) mask <= host_wr_data;
            irq <= |(status & mask);
        end
    end

    assert_irq_set_R1: assert property (@(posedge clk) disable iff (rst)
        (|(status & mask)) |=> irq);
    assert_irq_clear_R1: assert property (@(posedge clk) disable iff (rst)
        !(|(status & mask)) |=> !irq);
    assert_tx_ovf_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_push && tx_level == LVL_W'(DEPTH)) |=> status[6]);
    assert_rx_udf_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && rx_level == '0) |=> status[9]);
    assert_mask_load_R12: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && host_wr_addr) |=> (mask == $past(host_wr_data)));
endmodule

// File: tb/serial_status_irq_tb.sv
module serial_status_irq_tb_top;
    localparam int DEPTH = 8;
    localparam int LVL_W = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic host_wr_en = 0, host_wr_addr = 0, host_rd_addr = 0;
    logic [11:0] host_wr_data = '0, host_rd_data;
    logic [LVL_W-1:0] tx_level = '0, rx_level = '0, tx_thresh = '0, rx_thresh = '0;
    logic tx_push = 0, rx_pop = 0, tx_slot = 0, rx_word = 0;
    logic tx_ctl_free = 0, rx_ctl_valid = 0, slave_mode = 0, sync_pulse = 0, bit_strobe = 0;
    logic [5:0] frame_bits = 6'd4;
    logic [2:0] data_slot = 3'd0, ctl_slot = 3'd1;
    logic ctl_slot_en = 0, irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    serial_status_irq #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr),
        .host_wr_data(host_wr_data), .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
        .tx_level(tx_level), .rx_level(rx_level), .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
        .tx_push(tx_push), .rx_pop(rx_pop), .tx_slot(tx_slot), .rx_word(rx_word),
        .tx_ctl_free(tx_ctl_free), .rx_ctl_valid(rx_ctl_valid), .slave_mode(slave_mode),
        .sync_pulse(sync_pulse), .bit_strobe(bit_strobe), .frame_bits(frame_bits),
        .data_slot(data_slot), .ctl_slot(ctl_slot), .ctl_slot_en(ctl_slot_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic hwrite(input logic addr, input logic [11:0] data);
        host_wr_en = 1; host_wr_addr = addr; host_wr_data = data;
        step();
        host_wr_en = 0; host_wr_data = '0;
    endtask

    function automatic logic [11:0] status_now();
        host_rd_addr = 0;
        return host_rd_data;
    endfunction

    initial begin
        step(); step(); step();
        rst = 0;
        tx_level = 4'd3; rx_level = 4'd3;
        #1;
        // R2
        host_rd_addr = 1; #1;
        chk("R2 mask", host_rd_data, 12'h0);
        host_rd_addr = 0; #1;
        chk("R2 errors", host_rd_data[11:6], 6'h0);
        chk("R2 irq", irq, 1'b0);

        // R3 sweep
        for (int t = 0; t <= DEPTH; t++)
            for (int l = 0; l <= DEPTH; l++) begin
                tx_level = LVL_W'(l); tx_thresh = LVL_W'(t); #1;
                chk("R3 tx req/empty", host_rd_data[1:0], {l == 0, l >= t});
            end
        // R4 sweep
        for (int t = 0; t <= DEPTH; t++)
            for (int l = 0; l <= DEPTH; l++) begin
                rx_level = LVL_W'(l); rx_thresh = LVL_W'(t); #1;
                chk("R4 rx req/full", host_rd_data[3:2], {l == DEPTH, l >= t});
            end
        // R5
        for (int p = 0; p < 4; p++) begin
            tx_ctl_free = p[0]; rx_ctl_valid = p[1]; #1;
            chk("R5 ctl bits", host_rd_data[5:4], p[1:0]);
        end
        tx_ctl_free = 0; rx_ctl_valid = 0;
        tx_level = 4'd3; rx_level = 4'd3; tx_thresh = 4'd8; rx_thresh = 4'd8;
        step();

        // R1: mask tx_empty only
        tx_level = 4'd0;
        hwrite(1'b1, 12'h002);
        chk("R1 irq after one edge", irq, 1'b0);
        step();
        chk("R1 irq after two edges", irq, 1'b1);
        tx_level = 4'd3;
        step();
        chk("R1 irq drops", irq, 1'b0);
        hwrite(1'b1, 12'h000);

        // R6 no-trigger then trigger
        tx_level = 4'd7; tx_push = 1; step(); tx_push = 0;
        chk("R6 push not full", status_now()[6], 1'b0);
        tx_level = 4'd8; tx_push = 1; step(); tx_push = 0;
        chk("R6 tx overflow", status_now()[6], 1'b1);
        tx_level = 4'd1; tx_slot = 1; step(); tx_slot = 0;
        chk("R6 slot not empty", status_now()[7], 1'b0);
        tx_level = 4'd0; tx_slot = 1; step(); tx_slot = 0;
        chk("R6 tx underflow", status_now()[7], 1'b1);
        tx_level = 4'd3;
        // R7
        rx_level = 4'd8; rx_word = 1; step(); rx_word = 0;
        chk("R7 rx overflow", status_now()[8], 1'b1);
        rx_level = 4'd1; rx_pop = 1; step(); rx_pop = 0;
        chk("R7 pop not empty", status_now()[9], 1'b0);
        rx_level = 4'd0; rx_pop = 1; step(); rx_pop = 0;
        chk("R7 rx underflow", status_now()[9], 1'b1);
        rx_level = 4'd3;

        // R10
        hwrite(1'b0, 12'h040);
        chk("R10 selective clear", status_now()[9:6], 4'b1110);
        hwrite(1'b0, 12'h000);
        chk("R10 zero write", status_now()[9:6], 4'b1110);
        tx_ctl_free = 1; #1;
        hwrite(1'b0, 12'h03F);
        chk("R10 level bits ignore write", status_now()[5:4], 2'b01);
        tx_ctl_free = 0;
        hwrite(1'b0, 12'hFC0);
        chk("R10 clear all", status_now()[11:6], 6'h00);

        // R11
        tx_level = 4'd8; tx_push = 1;
        hwrite(1'b0, 12'h040);
        tx_push = 0;
        chk("R11 event beats clear", status_now()[6], 1'b1);
        tx_level = 4'd3;
        hwrite(1'b0, 12'hFC0);

        // R8
        slave_mode = 1; frame_bits = 6'd4;
        sync_pulse = 1; step(); sync_pulse = 0;
        chk("R8 first sync", status_now()[10], 1'b0);
        bit_strobe = 1; step(); step(); bit_strobe = 0;
        sync_pulse = 1; step(); sync_pulse = 0;
        chk("R8 early sync", status_now()[10], 1'b1);
        hwrite(1'b0, 12'h400);
        bit_strobe = 1; for (int k = 0; k < 4; k++) step(); bit_strobe = 0;
        sync_pulse = 1; step(); sync_pulse = 0;
        chk("R8 on-time sync", status_now()[10], 1'b0);
        slave_mode = 0;
        sync_pulse = 1; step(); sync_pulse = 0;
        chk("R8 master early sync", status_now()[10], 1'b0);

        // R9
        data_slot = 3'd2; ctl_slot = 3'd2; ctl_slot_en = 0; step();
        chk("R9 unused ctl slot", status_now()[11], 1'b0);
        ctl_slot_en = 1; step();
        chk("R9 slot conflict", status_now()[11], 1'b1);
        ctl_slot = 3'd5;
        hwrite(1'b0, 12'h800);
        chk("R9 conflict gone", status_now()[11], 1'b0);

        // R12 and R1 with error flag
        hwrite(1'b1, 12'hABC);
        host_rd_addr = 1; #1;
        chk("R12 mask readback", host_rd_data, 12'hABC);
        host_rd_addr = 0;
        hwrite(1'b1, 12'h800);
        ctl_slot = 3'd2; step(); ctl_slot = 3'd5;
        chk("R1 irq not yet", irq, 1'b0);
        step();
        chk("R1 irq from error", irq, 1'b1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule